// File: doc/BRIEF.md
# Acquisition Control Register File

This block is the software-facing register set of a burst sample-acquisition engine. A processor reaches it through a small memory-mapped slave with a 3-bit word address, 32-bit data and single-cycle read and write strobes. Software programs how many samples to capture and where in memory they should go, then issues a one-shot start. The block tells a companion DMA write master to begin, counts the samples that the data path reports as delivered, and raises a completion flag once the programmed number has arrived.

The block also keeps two sticky error flags. One records a sample-buffer overflow reported by the data path. The other records a bus write aimed at the read-only status word. A third duty is passing a 16-bit configuration word down to the converter driver. Software first writes the word into a holding register and then asks for it to be forwarded. The block presents a snapshot of the word with a request level and keeps both steady until the driver acknowledges them.

Register map (word offsets): 0 = control, 1 = sample count, 2 = base address, 3 = status (read-only), 4 = configuration word (write-only). Control bits: bit 0 start, bit 1 soft reset, bit 2 fixed destination address, bit 3 forward configuration word. Status bits: bit 0 done, bit 1 overflow, bit 2 illegal write.

Top module: `acq_regfile`

## Requirements
- R1: After reset all registers, status bits and outputs are zero, and reads of every offset return zero.
- R2: Offsets 1 (sample count) and 2 (base address) are 32-bit read/write registers whose contents drive dma_count_o and dma_base_o.
- R3: Writing control bit 0 raises dma_start_o for exactly the one cycle after the write, and writing bit 1 does the same on dma_reset_o. Control bit 2 is a stored level on dma_fixed_addr_o. A control read returns bit 2 only; all other bits read as zero.
- R4: Status bit 0 sets in the cycle after the delivered sample that brings the count since the last start up to the programmed count. Samples are counted only between a start and completion. A start clears bit 0, and a start with a count of zero sets bit 0 at once.
- R5: A pulse on buf_overflow_i sets status bit 1, which stays set until the next start or soft reset.
- R6: A write to offset 3 changes no register and sets status bit 2, which stays set until the next start or soft reset.
- R7: A start or soft reset clears status bits 1 and 2. An error event in the same cycle still sets its bit. A soft reset also clears bit 0 and stops counting, and it wins over a start written in the same word.
- R8: A write to offset 4 stores the low 16 bits as the configuration word. Reads of offsets 4 to 7 return zero, and writes to offsets 5 to 7 have no effect.
- R9: Control bit 3, written while no forward is pending, raises cfg_req_o with a snapshot of the stored word on cfg_word_o. Both hold until cfg_ack_i is seen, and cfg_req_o is low from the cycle after the acknowledge. A forward written while one is pending is ignored.
- R10: rdata_o takes the value of the addressed register in the cycle after rd_en_i and holds it while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| wr_en_i | input | 1 | Slave write strobe |
| rd_en_i | input | 1 | Slave read strobe |
| addr_i | input | 3 | Slave word address |
| wdata_i | input | 32 | Slave write data |
| rdata_o | output | 32 | Slave read data, registered |
| sample_valid_i | input | 1 | One sample delivered this cycle |
| buf_overflow_i | input | 1 | Sample buffer overflow event |
| dma_start_o | output | 1 | One-cycle start pulse to the write master |
| dma_reset_o | output | 1 | One-cycle soft-reset pulse to the write master |
| dma_fixed_addr_o | output | 1 | Write master keeps one destination address |
| dma_count_o | output | 32 | Programmed sample count |
| dma_base_o | output | 32 | Programmed base address |
| cfg_req_o | output | 1 | Configuration word forward pending |
| cfg_word_o | output | 16 | Configuration word presented to the driver |
| cfg_ack_i | input | 1 | Driver has taken the configuration word |

## Verification
The hardest situation to reach from the ports is a completion that coincides with other activity. Examples are samples that arrive before the start, error events falling between samples, and a soft reset in the middle of a run. The stimulus drives randomly sized acquisitions with random gaps between samples and random overflow pulses inside those gaps. A bench model tracks the expected status word, and the status is read just before and just after the final sample. Directed cases add a zero-length run, a start and soft reset in one write, and a second forward while the first is still pending.

// File: rtl/acq_regs_pkg.sv
package acq_regs_pkg;
   localparam int unsigned MAP_ADDR_W = 3;
   localparam int unsigned NUM_REGS   = 5;

   localparam logic [MAP_ADDR_W-1:0] OFS_CTRL  = 3'd0;
   localparam logic [MAP_ADDR_W-1:0] OFS_COUNT = 3'd1;
   localparam logic [MAP_ADDR_W-1:0] OFS_BASE  = 3'd2;
   localparam logic [MAP_ADDR_W-1:0] OFS_STAT  = 3'd3;
   localparam logic [MAP_ADDR_W-1:0] OFS_CFG   = 3'd4;

   localparam int unsigned CTL_START = 0;
   localparam int unsigned CTL_SRST  = 1;
   localparam int unsigned CTL_FIXED = 2;
   localparam int unsigned CTL_FWD   = 3;

   localparam int unsigned STS_DONE  = 0;
   localparam int unsigned STS_OVF   = 1;
   localparam int unsigned STS_ROERR = 2;

   typedef struct packed {
      logic ro_err;
      logic ovf;
      logic done;
   } status_t;
endpackage

// File: rtl/acq_bus_decode.sv
module acq_bus_decode
   import acq_regs_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 32
) (
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [NUM_REGS-1:0] sel_wr_o,
   output logic              start_o,
   output logic              srst_o,
   output logic              fwd_o,
   output logic              ro_hit_o
);
   if (NUM_REGS > (1 << ADDR_W)) begin : g_bad_addr
      $error("acq_bus_decode: address too narrow for register map");
   end
   if (DATA_W <= CTL_FWD) begin : g_bad_data
      $error("acq_bus_decode: data bus narrower than control word");
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
      assign sel_wr_o[g] = wr_en_i && (addr_i == ADDR_W'(g));
   end

   assign start_o  = sel_wr_o[OFS_CTRL] && wdata_i[CTL_START];
   assign srst_o   = sel_wr_o[OFS_CTRL] && wdata_i[CTL_SRST];
   assign fwd_o    = sel_wr_o[OFS_CTRL] && wdata_i[CTL_FWD];
   assign ro_hit_o = sel_wr_o[OFS_STAT];
endmodule

// File: rtl/acq_progress.sv
module acq_progress #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             start_i,
   input  logic             clear_i,
   input  logic             sample_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             active_o,
   output logic             done_o
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("acq_progress: counter width must be positive");
   end

   logic [CNT_W-1:0] seen_q;
   logic [CNT_W-1:0] seen_nxt;
   logic             active_q;
   logic             done_q;

   assign seen_nxt = seen_q + 1'b1;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         seen_q   <= '0;
         active_q <= 1'b0;
         done_q   <= 1'b0;
      end else if (clear_i) begin
         seen_q   <= '0;
         active_q <= 1'b0;
         done_q   <= 1'b0;
      end else if (start_i) begin
         seen_q   <= '0;
         active_q <= (limit_i != '0);
         done_q   <= (limit_i == '0);
      end else if (active_q && sample_i) begin
         seen_q <= seen_nxt;
         if (seen_nxt >= limit_i) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
         end
      end
   end

   assign active_o = active_q;
   assign done_o   = done_q;

   AST_DONE_ENDS_RUN: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |-> !active_o); // R4
   AST_START_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
      (start_i && !clear_i && limit_i != '0) |=> (!done_o && active_o)); // R4
   AST_SRST_STOPS_RUN: assert property (@(posedge clk_i) disable iff (rst_i)
      clear_i |=> (!active_o && !done_o)); // R7
endmodule

// File: rtl/acq_sticky_flags.sv
module acq_sticky_flags (
   input  logic clk_i,
   input  logic rst_i,
   input  logic clear_i,
   input  logic ovf_evt_i,
   input  logic ro_evt_i,
   output logic ovf_o,
   output logic ro_err_o
);
   logic ovf_q;
   logic ro_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         ovf_q <= 1'b0;
         ro_q  <= 1'b0;
      end else begin
         ovf_q <= (ovf_q && !clear_i) || ovf_evt_i;
         ro_q  <= (ro_q  && !clear_i) || ro_evt_i;
      end
   end

   assign ovf_o    = ovf_q;
   assign ro_err_o = ro_q;

   AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
      (ovf_o && !clear_i) |=> ovf_o); // R5
   AST_OVF_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
      ovf_evt_i |=> ovf_o); // R5
   AST_RO_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
      ro_evt_i |=> ro_err_o); // R6
   AST_FLAGS_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
      (clear_i && !ovf_evt_i && !ro_evt_i) |=> (!ovf_o && !ro_err_o)); // R7
endmodule

// File: rtl/acq_cfg_link.sv
module acq_cfg_link #(
   parameter int unsigned CFG_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             fwd_i,
   input  logic [CFG_W-1:0] word_i,
   input  logic             ack_i,
   output logic             req_o,
   output logic [CFG_W-1:0] word_o
);
   logic             req_q;
   logic [CFG_W-1:0] word_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         req_q  <= 1'b0;
         word_q <= '0;
      end else if (req_q) begin
         if (ack_i) begin
            req_q <= 1'b0;
         end
      end else if (fwd_i) begin
         req_q  <= 1'b1;
         word_q <= word_i;
      end
   end

   assign req_o  = req_q;
   assign word_o = word_q;

   AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      (req_o && !ack_i) |=> (req_o && $stable(word_o))); // R9
   AST_CFG_RELEASE: assert property (@(posedge clk_i) disable iff (rst_i)
      (req_o && ack_i) |=> !req_o); // R9
   AST_CFG_LAUNCH: assert property (@(posedge clk_i) disable iff (rst_i)
      (!req_o && fwd_i) |=> (req_o && word_o == $past(word_i))); // R9
endmodule

// File: rtl/acq_regfile.sv
module acq_regfile
   import acq_regs_pkg::*;
#(
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned CFG_W     = 16,
   parameter bit          RDATA_REG = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              sample_valid_i,
   input  logic              buf_overflow_i,
   output logic              dma_start_o,
   output logic              dma_reset_o,
   output logic              dma_fixed_addr_o,
   output logic [CNT_W-1:0]  dma_count_o,
   output logic [DATA_W-1:0] dma_base_o,
   output logic              cfg_req_o,
   output logic [CFG_W-1:0]  cfg_word_o,
   input  logic              cfg_ack_i
);
   localparam int unsigned STS_W = $bits(status_t);

   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("acq_regfile: count wider than data bus");
   end
   if (CFG_W > DATA_W) begin : g_bad_cfg
      $error("acq_regfile: config word wider than data bus");
   end
   if (ADDR_W != MAP_ADDR_W) begin : g_bad_map
      $error("acq_regfile: address width must match register map");
   end

   logic [NUM_REGS-1:0] sel_wr;
   logic                start_w;
   logic                srst_w;
   logic                fwd_w;
   logic                ro_hit_w;

   acq_bus_decode #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_decode (
      .wr_en_i  (wr_en_i),
      .addr_i   (addr_i),
      .wdata_i  (wdata_i),
      .sel_wr_o (sel_wr),
      .start_o  (start_w),
      .srst_o   (srst_w),
      .fwd_o    (fwd_w),
      .ro_hit_o (ro_hit_w)
   );

   logic [CNT_W-1:0]  count_q;
   logic [DATA_W-1:0] base_q;
   logic              fixed_q;
   logic [CFG_W-1:0]  cfg_hold_q;
   logic              start_q;
   logic              srst_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         count_q    <= '0;
         base_q     <= '0;
         fixed_q    <= 1'b0;
         cfg_hold_q <= '0;
         start_q    <= 1'b0;
         srst_q     <= 1'b0;
      end else begin
         start_q <= start_w;
         srst_q  <= srst_w;
         if (sel_wr[OFS_COUNT]) count_q    <= wdata_i[CNT_W-1:0];
         if (sel_wr[OFS_BASE])  base_q     <= wdata_i;
         if (sel_wr[OFS_CTRL])  fixed_q    <= wdata_i[CTL_FIXED];
         if (sel_wr[OFS_CFG])   cfg_hold_q <= wdata_i[CFG_W-1:0];
      end
   end

   status_t sts;
   logic    run_active;

   acq_progress #(
      .CNT_W (CNT_W)
   ) u_progress (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .start_i  (start_w),
      .clear_i  (srst_w),
      .sample_i (sample_valid_i),
      .limit_i  (count_q),
      .active_o (run_active),
      .done_o   (sts.done)
   );

   acq_sticky_flags u_flags (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .clear_i   (start_w || srst_w),
      .ovf_evt_i (buf_overflow_i),
      .ro_evt_i  (ro_hit_w),
      .ovf_o     (sts.ovf),
      .ro_err_o  (sts.ro_err)
   );

   acq_cfg_link #(
      .CFG_W (CFG_W)
   ) u_cfg (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .fwd_i  (fwd_w),
      .word_i (cfg_hold_q),
      .ack_i  (cfg_ack_i),
      .req_o  (cfg_req_o),
      .word_o (cfg_word_o)
   );

   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      unique case (addr_i)
         OFS_CTRL:  rd_mux[CTL_FIXED] = fixed_q;
         OFS_COUNT: rd_mux = DATA_W'(count_q);
         OFS_BASE:  rd_mux = base_q;
         OFS_STAT:  rd_mux[STS_W-1:0] = sts;
         default:   rd_mux = '0;
      endcase
   end

   if (RDATA_REG) begin : g_rd_flop
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk_i or posedge rst_i) begin
         if (rst_i) begin
            rdata_q <= '0;
         end else if (rd_en_i) begin
            rdata_q <= rd_mux;
         end
      end
      assign rdata_o = rdata_q;

      AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
         !rd_en_i |=> $stable(rdata_o)); // R10
   end else begin : g_rd_comb
      assign rdata_o = rd_en_i ? rd_mux : '0;
   end

   assign dma_start_o      = start_q;
   assign dma_reset_o      = srst_q;
   assign dma_fixed_addr_o = fixed_q;
   assign dma_count_o      = count_q;
   assign dma_base_o       = base_q;

   AST_START_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
      dma_start_o |-> $past(wr_en_i && addr_i == OFS_CTRL && wdata_i[CTL_START])); // R3
   AST_SRST_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
      dma_reset_o |-> $past(wr_en_i && addr_i == OFS_CTRL && wdata_i[CTL_SRST])); // R3
   AST_RO_WRITE_INERT: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_en_i && addr_i == OFS_STAT) |=> ($stable(count_q) && $stable(base_q) && $stable(fixed_q))); // R6
   AST_SPARE_WRITE_INERT: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_en_i && addr_i > OFS_CFG) |=> ($stable(count_q) && $stable(base_q) && $stable(cfg_hold_q))); // R8
   AST_DONE_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(sts.done) |-> ($past(run_active) || $past(start_w))); // R4
endmodule

// File: tb/sim_acq_regfile.sv
module sim_acq_regfile;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        sample_v = 1'b0;
   logic        ovf = 1'b0;
   logic        dma_start, dma_reset, dma_fixed;
   logic [31:0] dma_count, dma_base;
   logic        cfg_req;
   logic [15:0] cfg_word;
   logic        cfg_ack = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   acq_regfile u0 (
      .clk_i (clk), .rst_i (rst),
      .wr_en_i (wr_en), .rd_en_i (rd_en), .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata),
      .sample_valid_i (sample_v), .buf_overflow_i (ovf),
      .dma_start_o (dma_start), .dma_reset_o (dma_reset), .dma_fixed_addr_o (dma_fixed),
      .dma_count_o (dma_count), .dma_base_o (dma_base),
      .cfg_req_o (cfg_req), .cfg_word_o (cfg_word), .cfg_ack_i (cfg_ack)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0; d = rdata;
   endtask

   task automatic samples(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); sample_v = 1'b1;
         @(negedge clk); sample_v = 1'b0;
      end
   endtask

   task automatic ovf_pulse();
      @(negedge clk); ovf = 1'b1;
      @(negedge clk); ovf = 1'b0;
   endtask

   function automatic logic [31:0] sts_word(input bit ro, input bit ov, input bit dn);
      return {29'd0, ro, ov, dn};
   endfunction

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      logic [31:0] v, c, b;
      bit ovf_m;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R1 reset state
      chk("R1 outputs", {dma_start, dma_reset, dma_fixed, cfg_req}, 32'h0);
      chk("R1 count/base", dma_count | dma_base, 32'h0);
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v); chk("R1 read zero", v, 32'h0);
      end

      // R2 read/write registers
      wr(3'd1, 32'hDEAD_BEEF); wr(3'd2, 32'h1234_5678);
      rd(3'd1, v); chk("R2 count read", v, 32'hDEAD_BEEF);
      rd(3'd2, v); chk("R2 base read", v, 32'h1234_5678);
      chk("R2 count out", dma_count, 32'hDEAD_BEEF);
      chk("R2 base out", dma_base, 32'h1234_5678);

      // R3 pulses and fixed level
      wr(3'd0, 32'h1);
      chk("R3 start pulse", dma_start, 1);
      @(negedge clk); chk("R3 start one cycle", dma_start, 0);
      wr(3'd0, 32'h2);
      chk("R3 srst pulse", dma_reset, 1);
      @(negedge clk); chk("R3 srst one cycle", dma_reset, 0);
      wr(3'd0, 32'hFFFF_FFF4);
      chk("R3 fixed level", dma_fixed, 1);
      rd(3'd0, v); chk("R3 ctrl read", v, 32'h4);
      wr(3'd0, 32'h0);
      chk("R3 fixed cleared", dma_fixed, 0);

      // R4 completion
      wr(3'd1, 32'd3);
      samples(2);
      wr(3'd0, 32'h1);
      samples(2);
      rd(3'd3, v); chk("R4 pre-start samples ignored", v, sts_word(0,0,0));
      samples(1);
      rd(3'd3, v); chk("R4 done set", v, sts_word(0,0,1));
      samples(2);
      rd(3'd3, v); chk("R4 done holds", v, sts_word(0,0,1));
      wr(3'd0, 32'h1);
      rd(3'd3, v); chk("R4 start clears done", v, sts_word(0,0,0));
      wr(3'd1, 32'd0); wr(3'd0, 32'h1);
      rd(3'd3, v); chk("R4 zero count done", v, sts_word(0,0,1));

      // R5 overflow sticky
      ovf_pulse();
      repeat (3) @(negedge clk);
      rd(3'd3, v); chk("R5 ovf sticky", v, sts_word(0,1,1));

      // R6 read-only write
      wr(3'd1, 32'd7);
      wr(3'd3, 32'hFFFF_FFFF);
      rd(3'd3, v); chk("R6 ro error", v, sts_word(1,1,1));
      rd(3'd1, v); chk("R6 count untouched", v, 32'd7);
      chk("R6 fixed untouched", dma_fixed, 0);

      // R7 start clears errors, soft reset stops run
      wr(3'd0, 32'h1);
      rd(3'd3, v); chk("R7 start clears flags", v, sts_word(0,0,0));
      wr(3'd3, 32'h0);
      wr(3'd0, 32'h2);
      rd(3'd3, v); chk("R7 srst clears flags", v, sts_word(0,0,0));
      samples(7);
      rd(3'd3, v); chk("R7 srst stops run", v, sts_word(0,0,0));
      wr(3'd1, 32'd2); wr(3'd0, 32'h3);
      samples(2);
      rd(3'd3, v); chk("R7 srst beats start", v, sts_word(0,0,0));

      // R8 config register and spare offsets
      wr(3'd4, 32'hABCD_1234);
      rd(3'd4, v); chk("R8 cfg write-only", v, 32'h0);
      wr(3'd5, 32'hFFFF_FFFF); wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
      rd(3'd1, v); chk("R8 spare no effect count", v, 32'd2);
      rd(3'd2, v); chk("R8 spare no effect base", v, 32'h1234_5678);
      rd(3'd7, v); chk("R8 spare reads zero", v, 32'h0);
      chk("R8 no stray forward", cfg_req, 0);

      // R9 forward handshake
      wr(3'd0, 32'h8);
      chk("R9 req raised", cfg_req, 1);
      chk("R9 word", cfg_word, 32'h1234);
      wr(3'd4, 32'h5555);
      wr(3'd0, 32'h8);
      chk("R9 pending forward ignored", cfg_word, 32'h1234);
      @(negedge clk); cfg_ack = 1'b1;
      @(negedge clk); cfg_ack = 1'b0;
      chk("R9 req released", cfg_req, 0);
      wr(3'd0, 32'h8);
      chk("R9 second forward", {cfg_req, 15'd0, cfg_word}, {1'b1, 15'd0, 16'h5555});
      @(negedge clk); cfg_ack = 1'b1;
      @(negedge clk); cfg_ack = 1'b0;

      // R10 read data holds
      rd(3'd2, v);
      wr(3'd2, 32'h0BAD_F00D);
      repeat (3) @(negedge clk);
      chk("R10 rdata holds", rdata, 32'h1234_5678);

      // Random acquisitions (R4, R5, R2)
      for (int it = 0; it < 40; it++) begin
         c = 32'($urandom_range(1, 10));
         b = $urandom;
         wr(3'd2, b);
         rd(3'd2, v); chk("R2 random base", v, b);
         wr(3'd1, c);
         wr(3'd0, 32'h1);
         ovf_m = 0;
         for (int k = 0; k < int'(c); k++) begin
            int gap = $urandom_range(0, 3);
            for (int g = 0; g < gap; g++) begin
               if ($urandom_range(0, 7) == 0) begin
                  ovf_pulse(); ovf_m = 1;
               end else begin
                  @(negedge clk);
               end
            end
            if (k == int'(c) - 1) begin
               rd(3'd3, v); chk("R4 random before last", v, sts_word(0, ovf_m, 0));
            end
            samples(1);
         end
         rd(3'd3, v); chk("R4 random done", v, sts_word(0, ovf_m, 1));
      end

      summary();
   end
endmodule